// File: doc/BRIEF.md
# Contiguous Transfer Descriptor Merger

This block sits between a producer of small transfer descriptors and a DMA engine. Each input descriptor names a start address, a byte length and a destination ID. The block keeps one pending request. When a new descriptor continues that request exactly (same destination, starting where the pending span ends) it is absorbed, and the span grows. Otherwise the pending request is handed to an output stage, and the new descriptor becomes the pending request. The output stage issues each request in arrival order. It cuts any request longer than the maximum burst into consecutive pieces.

Merging is limited by two rules. The pending request and the new descriptor must both start on the alignment boundary, which is 64 bytes by default. The merged total must also stay within the maximum burst. The pending request is issued when a descriptor breaks the run, when `flush_i` is asserted, or when it has waited `idle_limit_i` cycles with no input. Every output beat carries the number of input descriptors that went into its request. Both sides use valid/ready handshakes.

Top module: `desc_merger`

## Requirements
- R1: After reset `out_valid_o` is low and `in_ready_o` is high.
- R2: A descriptor joins the pending request only if all of the following hold: its destination matches, its address equals the pending start plus the pending length, both starts are aligned, and the summed length is at most MAX_BURST. The request is then issued once, with the first start address, the summed length and `out_frags_o` equal to the number of descriptors merged. `out_frags_o` is never 0.
- R3: A descriptor that is non-contiguous or has a different destination causes the pending request to be issued unchanged. The new descriptor starts a new request. Requests leave in arrival order.
- R4: A contiguous descriptor whose start is not a multiple of ALIGN_BYTES (64) is not merged and starts a new request. A pending request whose start is misaligned accepts no further descriptors. Any output with `out_frags_o` > 1 has an aligned address.
- R5: A descriptor that would push the summed length past MAX_BURST (256) is not merged. A request longer than MAX_BURST is issued as pieces of MAX_BURST bytes at ascending addresses, followed by a final piece holding the remainder. Each piece carries the request's fragment count. No output length exceeds MAX_BURST.
- R6: A one-cycle `flush_i` issues the pending request. A descriptor accepted in the same cycle never joins it and becomes the next pending request.
- R7: With `idle_limit_i` = L ≠ 0, consider a pending request that receives no further input. It appears on the output L+1 clock edges after the edge that accepted its last descriptor. With L = 0 it is never issued by timeout.
- R8: While `out_valid_o` is high and `out_ready_i` is low, all output fields hold steady.
- R9: `in_ready_o` goes low only when an arriving descriptor or flush needs the output stage while that stage still holds an unaccepted beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input descriptor valid |
| in_ready_o | output | 1 | Input descriptor accepted when high with valid |
| in_addr_i | input | ADDR_W | Input start address (bytes) |
| in_len_i | input | LEN_W | Input length (bytes, nonzero) |
| in_dest_i | input | DEST_W | Input destination ID |
| flush_i | input | 1 | Issue the pending request now |
| idle_limit_i | input | IDLE_W | Idle cycles before a pending request is issued, 0 disables |
| out_valid_o | output | 1 | Output request valid |
| out_ready_i | input | 1 | DMA engine accepts the output request |
| out_addr_o | output | ADDR_W | Output start address |
| out_len_o | output | LEN_W | Output length, at most MAX_BURST |
| out_dest_o | output | DEST_W | Output destination ID |
| out_frags_o | output | FRAG_W | Input descriptors merged into this request |

## Verification
Several properties are checked on every cycle: outputs hold while stalled, output lengths stay in range, the fragment count is never zero, merged outputs start aligned, and the input stalls only while an output beat is pending. Scenarios alone can show the following:
- which descriptors actually merge and in what order requests leave;
- the exact split pieces of an oversize request;
- that a flush-cycle descriptor stays separate;
- the exact cycle at which the idle timeout fires.

// File: rtl/desc_merger_pkg.sv
package desc_merger_pkg;
  localparam int unsigned DM_ADDR_W = 32;
  localparam int unsigned DM_LEN_W  = 16;
  localparam int unsigned DM_DEST_W = 4;
  localparam int unsigned DM_FRAG_W = 6;
  localparam int unsigned DM_IDLE_W = 8;

  typedef enum logic [1:0] {
    FC_NONE  = 2'd0,
    FC_BREAK = 2'd1,
    FC_FORCE = 2'd2,
    FC_IDLE  = 2'd3
  } flush_cause_e;
endpackage

// File: rtl/dm_join_check.sv
module dm_join_check #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned DEST_W    = 4,
  parameter int unsigned FRAG_W    = 6,
  parameter int unsigned ALIGN_LSB = 6,
  parameter int unsigned MAX_BURST = 256
) (
  input  logic              pend_valid_i,
  input  logic [ADDR_W-1:0] pend_addr_i,
  input  logic [LEN_W-1:0]  pend_len_i,
  input  logic [DEST_W-1:0] pend_dest_i,
  input  logic [FRAG_W-1:0] pend_frags_i,
  input  logic [ADDR_W-1:0] in_addr_i,
  input  logic [LEN_W-1:0]  in_len_i,
  input  logic [DEST_W-1:0] in_dest_i,
  output logic              join_ok_o
);
  localparam int unsigned SUM_W = LEN_W + 1;

  logic in_aligned, pend_aligned, contiguous, fits, same_dest, room;
  logic [SUM_W-1:0] sum_len;

  generate
    if (ALIGN_LSB == 0) begin : g_no_align
      assign in_aligned   = 1'b1;
      assign pend_aligned = 1'b1;
    end else begin : g_align
      assign in_aligned   = (in_addr_i[ALIGN_LSB-1:0] == '0);
      assign pend_aligned = (pend_addr_i[ALIGN_LSB-1:0] == '0);
    end
  endgenerate

  always_comb begin
    sum_len    = {1'b0, pend_len_i} + {1'b0, in_len_i};
    contiguous = (pend_addr_i + ADDR_W'(pend_len_i)) == in_addr_i;
    fits       = sum_len <= SUM_W'(MAX_BURST);
    same_dest  = pend_dest_i == in_dest_i;
    room       = pend_frags_i != '1;
    join_ok_o  = pend_valid_i && contiguous && same_dest && fits && room
                 && in_aligned && pend_aligned;
  end
endmodule

// File: rtl/dm_pending.sv
module dm_pending
  import desc_merger_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned DEST_W = 4,
  parameter int unsigned FRAG_W = 6,
  parameter int unsigned IDLE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [ADDR_W-1:0] in_addr_i,
  input  logic [LEN_W-1:0]  in_len_i,
  input  logic [DEST_W-1:0] in_dest_i,
  output logic              in_ready_o,
  input  logic              flush_i,
  input  logic [IDLE_W-1:0] idle_limit_i,
  input  logic              join_ok_i,
  input  logic              em_free_i,
  output logic              xfer_o,
  output logic              pend_valid_o,
  output logic [ADDR_W-1:0] pend_addr_o,
  output logic [LEN_W-1:0]  pend_len_o,
  output logic [DEST_W-1:0] pend_dest_o,
  output logic [FRAG_W-1:0] pend_frags_o
);
  logic [IDLE_W-1:0] idle_cnt;
  logic idle_hit, merge_ok, in_fire;
  flush_cause_e cause;

  always_comb begin
    idle_hit = pend_valid_o && (idle_limit_i != '0) && (idle_cnt >= idle_limit_i);
    merge_ok = join_ok_i && !flush_i && !idle_hit;
    if (!pend_valid_o)                   cause = FC_NONE;
    else if (flush_i)                    cause = FC_FORCE;
    else if (idle_hit)                   cause = FC_IDLE;
    else if (in_valid_i && !merge_ok)    cause = FC_BREAK;
    else                                 cause = FC_NONE;
    xfer_o     = (cause != FC_NONE) && em_free_i;
    in_ready_o = !pend_valid_o || merge_ok || em_free_i;
    in_fire    = in_valid_i && in_ready_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_valid_o <= 1'b0;
      pend_addr_o  <= '0;
      pend_len_o   <= '0;
      pend_dest_o  <= '0;
      pend_frags_o <= '0;
    end else if (xfer_o || (in_fire && !pend_valid_o)) begin
      pend_valid_o <= in_fire;
      if (in_fire) begin
        pend_addr_o  <= in_addr_i;
        pend_len_o   <= in_len_i;
        pend_dest_o  <= in_dest_i;
        pend_frags_o <= FRAG_W'(1);
      end
    end else if (in_fire) begin
      pend_len_o   <= pend_len_o + in_len_i;
      pend_frags_o <= pend_frags_o + FRAG_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              idle_cnt <= '0;
    else if (in_fire || xfer_o || !pend_valid_o) idle_cnt <= '0;
    else if (idle_cnt != '1)                  idle_cnt <= idle_cnt + IDLE_W'(1);
  end
endmodule

// File: rtl/dm_splitter.sv
module dm_splitter #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned DEST_W    = 4,
  parameter int unsigned FRAG_W    = 6,
  parameter int unsigned MAX_BURST = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [LEN_W-1:0]  ld_len_i,
  input  logic [DEST_W-1:0] ld_dest_i,
  input  logic [FRAG_W-1:0] ld_frags_i,
  output logic              em_free_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [LEN_W-1:0]  out_len_o,
  output logic [DEST_W-1:0] out_dest_o,
  output logic [FRAG_W-1:0] out_frags_o
);
  localparam logic [LEN_W-1:0]  MAX_L = LEN_W'(MAX_BURST);
  localparam logic [ADDR_W-1:0] MAX_A = ADDR_W'(MAX_BURST);

  logic [LEN_W-1:0] rem_len;
  logic last_piece, out_fire;

  always_comb begin
    last_piece = rem_len <= MAX_L;
    out_fire   = out_valid_o && out_ready_i;
    em_free_o  = !out_valid_o || (out_ready_i && last_piece);
    out_len_o  = last_piece ? rem_len : MAX_L;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_addr_o  <= '0;
      rem_len     <= '0;
      out_dest_o  <= '0;
      out_frags_o <= '0;
    end else if (load_i) begin
      out_valid_o <= 1'b1;
      out_addr_o  <= ld_addr_i;
      rem_len     <= ld_len_i;
      out_dest_o  <= ld_dest_i;
      out_frags_o <= ld_frags_i;
    end else if (out_fire) begin
      if (last_piece) begin
        out_valid_o <= 1'b0;
      end else begin
        out_addr_o <= out_addr_o + MAX_A;
        rem_len    <= rem_len - MAX_L;
      end
    end
  end
endmodule

// File: rtl/desc_merger.sv
module desc_merger
  import desc_merger_pkg::*;
#(
  parameter int unsigned ADDR_W      = DM_ADDR_W,
  parameter int unsigned LEN_W       = DM_LEN_W,
  parameter int unsigned DEST_W      = DM_DEST_W,
  parameter int unsigned FRAG_W      = DM_FRAG_W,
  parameter int unsigned IDLE_W      = DM_IDLE_W,
  parameter int unsigned ALIGN_BYTES = 64,
  parameter int unsigned MAX_BURST   = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [ADDR_W-1:0] in_addr_i,
  input  logic [LEN_W-1:0]  in_len_i,
  input  logic [DEST_W-1:0] in_dest_i,
  input  logic              flush_i,
  input  logic [IDLE_W-1:0] idle_limit_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [LEN_W-1:0]  out_len_o,
  output logic [DEST_W-1:0] out_dest_o,
  output logic [FRAG_W-1:0] out_frags_o
);
  localparam int unsigned ALIGN_LSB = $clog2(ALIGN_BYTES);

  logic              pend_valid, join_ok, em_free, xfer;
  logic [ADDR_W-1:0] pend_addr;
  logic [LEN_W-1:0]  pend_len;
  logic [DEST_W-1:0] pend_dest;
  logic [FRAG_W-1:0] pend_frags;

  dm_join_check #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEST_W(DEST_W), .FRAG_W(FRAG_W),
    .ALIGN_LSB(ALIGN_LSB), .MAX_BURST(MAX_BURST)
  ) u_join (
    .pend_valid_i(pend_valid), .pend_addr_i(pend_addr), .pend_len_i(pend_len),
    .pend_dest_i(pend_dest), .pend_frags_i(pend_frags),
    .in_addr_i(in_addr_i), .in_len_i(in_len_i), .in_dest_i(in_dest_i),
    .join_ok_o(join_ok)
  );

  dm_pending #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEST_W(DEST_W), .FRAG_W(FRAG_W), .IDLE_W(IDLE_W)
  ) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .in_valid_i(in_valid_i), .in_addr_i(in_addr_i), .in_len_i(in_len_i),
    .in_dest_i(in_dest_i), .in_ready_o(in_ready_o),
    .flush_i(flush_i), .idle_limit_i(idle_limit_i),
    .join_ok_i(join_ok), .em_free_i(em_free), .xfer_o(xfer),
    .pend_valid_o(pend_valid), .pend_addr_o(pend_addr), .pend_len_o(pend_len),
    .pend_dest_o(pend_dest), .pend_frags_o(pend_frags)
  );

  dm_splitter #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEST_W(DEST_W), .FRAG_W(FRAG_W),
    .MAX_BURST(MAX_BURST)
  ) u_split (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(xfer), .ld_addr_i(pend_addr), .ld_len_i(pend_len),
    .ld_dest_i(pend_dest), .ld_frags_i(pend_frags),
    .em_free_o(em_free),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_addr_o(out_addr_o), .out_len_o(out_len_o),
    .out_dest_o(out_dest_o), .out_frags_o(out_frags_o)
  );
endmodule

// File: rtl/desc_merger_chk.sv
module desc_merger_chk #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned LEN_W       = 16,
  parameter int unsigned DEST_W      = 4,
  parameter int unsigned FRAG_W      = 6,
  parameter int unsigned ALIGN_BYTES = 64,
  parameter int unsigned MAX_BURST   = 256
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [ADDR_W-1:0] out_addr_o,
  input logic [LEN_W-1:0]  out_len_o,
  input logic [DEST_W-1:0] out_dest_o,
  input logic [FRAG_W-1:0] out_frags_o
);
  localparam int unsigned ALIGN_LSB = $clog2(ALIGN_BYTES);
  localparam logic [ADDR_W-1:0] AMASK = ADDR_W'(ALIGN_BYTES - 1);

  p_out_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_addr_o)
      && $stable(out_len_o) && $stable(out_dest_o) && $stable(out_frags_o));

  p_len_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_len_o != '0) && (out_len_o <= LEN_W'(MAX_BURST)));

  p_frags_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_frags_o != '0);

  p_merged_aligned_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && (out_frags_o > FRAG_W'(1)) |-> (out_addr_o & AMASK) == '0);

  p_stall_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !in_ready_o |-> out_valid_o);

  p_reset_idle_r1: assert property (@(posedge clk_i)
    !rst_ni |-> !out_valid_o && in_ready_o);

  if (ALIGN_LSB > 30) begin : g_bad_align
    initial $error("alignment too large");
  end
endmodule

bind desc_merger desc_merger_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEST_W(DEST_W), .FRAG_W(FRAG_W),
  .ALIGN_BYTES(ALIGN_BYTES), .MAX_BURST(MAX_BURST)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_addr_o(out_addr_o),
  .out_len_o(out_len_o), .out_dest_o(out_dest_o), .out_frags_o(out_frags_o)
);

// File: tb/desc_merger_bench.sv
module desc_merger_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] in_addr_i = '0;
  logic [15:0] in_len_i = '0;
  logic [3:0]  in_dest_i = '0;
  logic        flush_i = 1'b0;
  logic [7:0]  idle_limit_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [31:0] out_addr_o;
  logic [15:0] out_len_o;
  logic [3:0]  out_dest_o;
  logic [5:0]  out_frags_o;

  int tests = 0;
  int fails = 0;

  always #5 clk_i = ~clk_i;

  desc_merger u_desc_merger (.*);

  // captured output beats: {addr, len, dest, frags}
  logic [57:0] got [64];
  int mon_n = 0;
  always @(posedge clk_i)
    if (rst_ni && out_valid_o && out_ready_i) begin
      if (mon_n < 64) got[mon_n] <= {out_addr_o, out_len_o, out_dest_o, out_frags_o};
      mon_n <= mon_n + 1;
    end

  // stimulus: {addr, len, dest}
  localparam logic [51:0] STIM [11] = '{
    {32'h1000, 16'd64,  4'd1},
    {32'h1040, 16'd64,  4'd1},
    {32'h1080, 16'd128, 4'd1},
    {32'h1100, 16'd64,  4'd1},
    {32'h1140, 16'd64,  4'd2},
    {32'h1180, 16'd64,  4'd2},
    {32'h2000, 16'd64,  4'd2},
    {32'h2040, 16'd32,  4'd2},
    {32'h2060, 16'd32,  4'd2},
    {32'h2080, 16'd64,  4'd2},
    {32'h3000, 16'd600, 4'd3}
  };
  // expected: {addr, len, dest, frags, requirement index}
  localparam logic [61:0] EXP [9] = '{
    {32'h1000, 16'd256, 4'd1, 6'd3, 4'd2},
    {32'h1100, 16'd64,  4'd1, 6'd1, 4'd3},
    {32'h1140, 16'd128, 4'd2, 6'd2, 4'd3},
    {32'h2000, 16'd96,  4'd2, 6'd2, 4'd4},
    {32'h2060, 16'd32,  4'd2, 6'd1, 4'd4},
    {32'h2080, 16'd64,  4'd2, 6'd1, 4'd3},
    {32'h3000, 16'd256, 4'd3, 6'd1, 4'd5},
    {32'h3100, 16'd256, 4'd3, 6'd1, 4'd5},
    {32'h3200, 16'd88,  4'd3, 6'd1, 4'd5}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] a, input logic [15:0] l, input logic [3:0] d);
    in_addr_i  = a;
    in_len_i   = l;
    in_dest_i  = d;
    in_valid_i = 1'b1;
    while (!in_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic pulse_flush();
    flush_i = 1'b1;
    @(negedge clk_i);
    flush_i = 1'b0;
  endtask

  task automatic chk_beat(input int idx, input logic [57:0] exp, input string req);
    chk(got[idx] == exp, req, 64'(got[idx]), 64'(exp));
  endtask

  function automatic string rname(input logic [3:0] n);
    case (n)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #1000000;
    fails++;
    tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int base;
    int n;
    @(negedge clk_i);
    // R1: reset state
    chk(out_valid_o == 1'b0, "R1", 64'(out_valid_o), 64'd0);
    chk(in_ready_o == 1'b1, "R1", 64'(in_ready_o), 64'd1);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R1", 64'(out_valid_o), 64'd0);

    // table walk: merging, breaks, alignment, split
    base = mon_n;
    for (int i = 0; i < 11; i++)
      send(STIM[i][51:20], STIM[i][19:4], STIM[i][3:0]);
    repeat (4) @(negedge clk_i);
    pulse_flush();
    repeat (8) @(negedge clk_i);
    chk(mon_n - base == 9, "R5", 64'(mon_n - base), 64'd9);
    for (int i = 0; i < 9; i++)
      chk_beat(base + i, EXP[i][61:4], rname(EXP[i][3:0]));

    // R8/R9: output stall holds fields and blocks input
    base = mon_n;
    out_ready_i = 1'b0;
    send(32'h4000, 16'd64, 4'd1);
    send(32'h5000, 16'd64, 4'd1);
    in_addr_i = 32'h6000; in_len_i = 16'd64; in_dest_i = 4'd1; in_valid_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(in_ready_o == 1'b0, "R9", 64'(in_ready_o), 64'd0);
    chk(out_valid_o && out_addr_o == 32'h4000, "R8", 64'(out_addr_o), 64'h4000);
    out_ready_i = 1'b1;
    while (!in_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    repeat (4) @(negedge clk_i);
    pulse_flush();
    repeat (4) @(negedge clk_i);
    chk_beat(base,     {32'h4000, 16'd64, 4'd1, 6'd1}, "R8");
    chk_beat(base + 1, {32'h5000, 16'd64, 4'd1, 6'd1}, "R3");
    chk_beat(base + 2, {32'h6000, 16'd64, 4'd1, 6'd1}, "R9");

    // R6: flush with a contiguous descriptor in the same cycle
    base = mon_n;
    send(32'h7000, 16'd64, 4'd1);
    in_addr_i = 32'h7040; in_len_i = 16'd64; in_dest_i = 4'd1;
    in_valid_i = 1'b1; flush_i = 1'b1;
    while (!in_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    in_valid_i = 1'b0; flush_i = 1'b0;
    repeat (3) @(negedge clk_i);
    pulse_flush();
    repeat (4) @(negedge clk_i);
    chk(mon_n - base == 2, "R6", 64'(mon_n - base), 64'd2);
    chk_beat(base,     {32'h7000, 16'd64, 4'd1, 6'd1}, "R6");
    chk_beat(base + 1, {32'h7040, 16'd64, 4'd1, 6'd1}, "R6");

    // R7: idle timeout of 5 cycles
    idle_limit_i = 8'd5;
    send(32'h8000, 16'd64, 4'd2);
    n = 0;
    while (!out_valid_o && n < 30) begin
      @(negedge clk_i);
      n++;
    end
    chk(n == 6, "R7", 64'(n), 64'd6);
    chk(out_addr_o == 32'h8000, "R7", 64'(out_addr_o), 64'h8000);
    @(negedge clk_i);
    idle_limit_i = 8'd0;
    send(32'h9000, 16'd64, 4'd2);
    repeat (30) @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R7", 64'(out_valid_o), 64'd0);
    pulse_flush();
    repeat (2) @(negedge clk_i);
    chk(got[mon_n - 1] == {32'h9000, 16'd64, 4'd2, 6'd1}, "R7",
        64'(got[mon_n - 1]), 64'({32'h9000, 16'd64, 4'd2, 6'd1}));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule